// File: doc/BRIEF.md
# Microcoded I2C Bus Sequencer

This block is an I2C bus master whose waveforms are not built by a fixed state machine. Software fills a microcode store of 1024 entries. Each entry sets the SCL and SDA levels for one bus step. It also says whether SDA is sampled during that step, whether the step counts as busy, and which entry runs next. A start pulse launches the program. The block then walks the linked entries until it reaches an entry whose busy flag is clear, and at that point it drops its busy status and releases both lines.

Every step lasts a fixed number of clock cycles, set by a parameter, so the bus rate can be tuned to the clock. SDA is sampled on the last cycle of every step that has read-enable set. The sampled bit shifts into a 32-bit result register from the least significant end, so the last byte received ends up in bits 7:0. The result register is cleared when a run starts. A read transfer therefore returns at most four bytes.

Software composes start conditions, bytes sent MSB first with acknowledge slots, and stop conditions as chains of entries. Entry 0 is the home entry: it is idle and points to itself.

Top module: `ucode_i2c_seq`

## Requirements
- R1: During and right after reset, busy is 0, rdData is 0 and neither line is driven low.
- R2: A microcode write stores one entry. The entry address is taken from ucWrData[27:18] and the next-entry pointer from bits 9:0. Bit 13 is the busy flag and bit 12 is read-enable. Bit 11 = 1 drives SCL low and bit 10 = 1 drives SDA low; a 0 in either bit releases that line.
- R3: A start pulse while idle begins a run at entry 1, which is the entry after the idle home entry 0. Busy reads 1 from the following cycle.
- R4: Each entry is executed for exactly STEP_DIV clock cycles, and then its next-entry pointer selects the following entry.
- R5: While running, each line is driven low exactly when the current entry's inverted-level bit is set. While idle, both lines are released.
- R6: A run ends when the completing step's successor has its busy flag clear, whether that successor is entry 0 or any other entry. Busy falls in the cycle after that step's last cycle.
- R7: On the last cycle of a read-enabled step, SDA is shifted in at bit 0 and earlier bits move up one place. After n bytes are read, the last byte sits in rdData[7:0]. rdData does not change while idle.
- R8: rdData is cleared to 0 when a run starts.
- R9: A start pulse during a run is ignored. The waveform and the collected result are unchanged.
- R10: A write-then-read program produces the programmed sequence of line levels, one level pair per step. That program is a start condition, an address byte, a register byte, a repeated start, an address byte with the read bit, 1 to 4 read bytes with NACK only on the last, and a stop that returns to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ucWrEn | input | 1 | Microcode write strobe |
| ucWrData | input | 32 | Microcode write word (address, flags, levels, next pointer) |
| startCmd | input | 1 | Start pulse; launches a run from entry 1 when idle |
| busy | output | 1 | High while a run is in progress |
| rdData | output | RES_W | Collected read bits, newest in bit 0 |
| sdaIn | input | 1 | Sensed SDA line level |
| sclDrvLow | output | 1 | Pull SCL low (open-drain enable) |
| sdaDrvLow | output | 1 | Pull SDA low (open-drain enable) |

## Verification
The bound checker watches four things on every cycle: busy rises after an idle start, the result reads zero after that start, both lines are released whenever the block is idle, and rdData holds still while idle. It also uses a counter to check that every run lasts a whole multiple of STEP_DIV cycles. The bench scenarios must cover what depends on the microcode content itself. That includes the step-by-step SCL/SDA levels of complete transfers with one to four read bytes, and the MSB-first assembly of the read bytes. It also includes a run that ends on a non-zero idle entry and a start pulse ignored mid-run.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
  // Word format of a microcode write; fields are decoded by the store.
  localparam int UC_ADDR_W  = 10;
  localparam int UC_DEPTH   = 1 << UC_ADDR_W;
  localparam int WF_SDA     = 10;
  localparam int WF_SCL     = 11;
  localparam int WF_RD      = 12;
  localparam int WF_BUSY    = 13;
  localparam int WF_ADDR_LO = 18;

  typedef struct packed {
    logic                 busy;
    logic                 rdEn;
    logic                 sclLow;
    logic                 sdaLow;
    logic [UC_ADDR_W-1:0] nxt;
  } ucEntry_t;

  typedef struct packed {
    logic clrRes;     // run launched: clear the result
    logic sampleBit;  // last cycle of a read step: shift SDA in
    logic lineEn;     // running: entry levels reach the pins
  } seqStrobe_t;
endpackage

// File: rtl/ucseq_datapath.sv
module ucseq_datapath
  import ucseq_pkg::*;
#(
  parameter int RES_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ucWrEn,
  input  logic [31:0]          ucWrData,
  input  logic [UC_ADDR_W-1:0] pc,
  input  seqStrobe_t           strobe,
  input  logic                 sdaIn,
  output ucEntry_t             curEntry,
  output logic                 nextBusy,
  output logic [RES_W-1:0]     rdData,
  output logic                 sclDrvLow,
  output logic                 sdaDrvLow
);
  ucEntry_t             store [UC_DEPTH];
  ucEntry_t             wrEntry;
  logic [UC_ADDR_W-1:0] wrAddr;
  logic [RES_W-1:0]     resQ;
  logic                 unusedWrBits;

  assign wrAddr         = ucWrData[WF_ADDR_LO +: UC_ADDR_W];
  assign wrEntry.busy   = ucWrData[WF_BUSY];
  assign wrEntry.rdEn   = ucWrData[WF_RD];
  assign wrEntry.sclLow = ucWrData[WF_SCL];
  assign wrEntry.sdaLow = ucWrData[WF_SDA];
  assign wrEntry.nxt    = ucWrData[UC_ADDR_W-1:0];
  assign unusedWrBits   = ^{ucWrData[31:WF_ADDR_LO+UC_ADDR_W],
                            ucWrData[WF_ADDR_LO-1:WF_BUSY+1]};

  always_ff @(posedge clk) begin
    if (ucWrEn) store[wrAddr] <= wrEntry;
  end

  // Current step and a look-ahead at its successor's busy flag.
  assign curEntry = store[pc];
  assign nextBusy = store[curEntry.nxt].busy;

  always_ff @(posedge clk) begin
    if (!rstN)                 resQ <= '0;
    else if (strobe.clrRes)    resQ <= '0;
    else if (strobe.sampleBit) resQ <= {resQ[RES_W-2:0], sdaIn};
  end

  assign rdData    = resQ;
  assign sclDrvLow = strobe.lineEn & curEntry.sclLow;
  assign sdaDrvLow = strobe.lineEn & curEntry.sdaLow;
endmodule

// File: rtl/ucseq_ctrl.sv
module ucseq_ctrl
  import ucseq_pkg::*;
#(
  parameter int STEP_DIV = 128
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startCmd,
  input  ucEntry_t             curEntry,
  input  logic                 nextBusy,
  output logic [UC_ADDR_W-1:0] pc,
  output logic                 busy,
  output seqStrobe_t           strobe
);
  localparam int DIV_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;

  logic                 running;
  logic [UC_ADDR_W-1:0] pcQ;
  logic                 launch;
  logic                 stepEnd;

  assign launch = startCmd & ~running;

  generate
    if (STEP_DIV == 1) begin : g_nodiv
      assign stepEnd = running;
    end else begin : g_div
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN || launch || stepEnd || !running) divCnt <= '0;
        else                                        divCnt <= divCnt + 1'b1;
      end
      assign stepEnd = running && (divCnt == DIV_W'(STEP_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      pcQ     <= '0;
    end else if (launch) begin
      running <= 1'b1;
      pcQ     <= UC_ADDR_W'(1);
    end else if (stepEnd) begin
      pcQ     <= curEntry.nxt;
      running <= nextBusy;
    end
  end

  assign pc               = pcQ;
  assign busy             = running;
  assign strobe.clrRes    = launch;
  assign strobe.sampleBit = stepEnd & curEntry.rdEn;
  assign strobe.lineEn    = running;
endmodule

// File: rtl/ucode_i2c_seq.sv
module ucode_i2c_seq
  import ucseq_pkg::*;
#(
  parameter int STEP_DIV = 128,
  parameter int RES_W    = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ucWrEn,
  input  logic [31:0]      ucWrData,
  input  logic             startCmd,
  output logic             busy,
  output logic [RES_W-1:0] rdData,
  input  logic             sdaIn,
  output logic             sclDrvLow,
  output logic             sdaDrvLow
);
  logic [UC_ADDR_W-1:0] pc;
  ucEntry_t             curEntry;
  logic                 nextBusy;
  seqStrobe_t           strobe;

  ucseq_ctrl #(.STEP_DIV(STEP_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .curEntry(curEntry),
    .nextBusy(nextBusy), .pc(pc), .busy(busy), .strobe(strobe)
  );

  ucseq_datapath #(.RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN), .ucWrEn(ucWrEn), .ucWrData(ucWrData), .pc(pc),
    .strobe(strobe), .sdaIn(sdaIn), .curEntry(curEntry), .nextBusy(nextBusy),
    .rdData(rdData), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow)
  );
endmodule

// File: rtl/ucode_i2c_seq_chk.sv
module ucode_i2c_seq_chk #(
  parameter int STEP_DIV = 128,
  parameter int RES_W    = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             startCmd,
  input logic             busy,
  input logic [RES_W-1:0] rdData,
  input logic             sclDrvLow,
  input logic             sdaDrvLow
);
  logic [31:0] busyCycles;

  always_ff @(posedge clk) begin
    if (!rstN)     busyCycles <= '0;
    else if (busy) busyCycles <= busyCycles + 32'd1;
    else           busyCycles <= '0;
  end

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startCmd && !busy) |=> busy);

  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startCmd && !busy) |=> (rdData == '0));

  // R5
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclDrvLow && !sdaDrvLow));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startCmd) |=> $stable(rdData));

  // R4
  step_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ((busyCycles % 32'(STEP_DIV)) == 32'd0));
endmodule

bind ucode_i2c_seq ucode_i2c_seq_chk #(.STEP_DIV(STEP_DIV), .RES_W(RES_W)) u_chk (
  .clk(clk), .rstN(rstN), .startCmd(startCmd), .busy(busy),
  .rdData(rdData), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow)
);

// File: tb/ucode_i2c_seq_tb.sv
`timescale 1ns/1ps
module ucode_i2c_seq_tb;
  localparam int DIV   = 4;
  localparam int RES_W = 32;
  // {device address[6:0], register byte[7:0], read count[2:0], slave pattern[31:0]}
  localparam logic [49:0] VEC [4] = '{
    {7'h1b, 8'h00, 3'd1, 32'hA5C3_0F96},
    {7'h1a, 8'hFE, 3'd2, 32'h1234_5678},
    {7'h19, 8'h3C, 3'd3, 32'hFFFF_0000},
    {7'h18, 8'h81, 3'd4, 32'h8000_0001}
  };

  logic clk = 1'b0, rstN = 1'b0, ucWrEn = 1'b0, startCmd = 1'b0;
  logic [31:0] ucWrData = '0;
  logic busy, sdaIn, sclDrvLow, sdaDrvLow;
  logic [RES_W-1:0] rdData;

  int nChecks = 0, nErr = 0;
  bit done = 1'b0;
  int riseCnt = 0, base = 0;
  logic [31:0] pat = '0;

  // builder state
  int pcW, riseB;
  bit prevScl, lScl, lSda, lRd;
  logic [31:0] expRes;
  bit expScl [512];
  bit expSda [512];

  always #4 clk = ~clk;

  // slave model: SCL rises are counted; released SDA returns the pattern bit
  always @(negedge sclDrvLow) riseCnt = riseCnt + 1;
  assign sdaIn = sdaDrvLow ? 1'b0 : pat[5'(riseCnt - base)];

  ucode_i2c_seq #(.STEP_DIV(DIV), .RES_W(RES_W)) u_dut (
    .clk(clk), .rstN(rstN), .ucWrEn(ucWrEn), .ucWrData(ucWrData),
    .startCmd(startCmd), .busy(busy), .rdData(rdData), .sdaIn(sdaIn),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic ucPut(input int addr, input bit bsy, input bit rd,
                       input bit scl, input bit sda, input int nxt);
    ucWrData = {4'b0, 10'(addr), 4'b0, bsy, rd, ~scl, ~sda, 10'(nxt)};
    ucWrEn   = 1'b1;
    @(negedge clk);
    ucWrEn   = 1'b0;
  endtask

  task automatic beginProg();
    pcW = 1; riseB = 0; prevScl = 1'b1; expRes = '0;
  endtask

  task automatic emit(input bit scl, input bit sda, input bit rd);
    if (scl && !prevScl) riseB++;
    prevScl = scl;
    if (rd) expRes = {expRes[30:0], pat[5'(riseB)]};
    expScl[pcW-1] = scl; expSda[pcW-1] = sda;
    lScl = scl; lSda = sda; lRd = rd;
    ucPut(pcW, 1'b1, rd, scl, sda, pcW + 1);
    pcW++;
  endtask

  task automatic endTo(input int tgt);
    ucPut(pcW - 1, 1'b1, lRd, lScl, lSda, tgt);
  endtask

  task automatic wrBit(input bit b);
    emit(1'b0, b, 1'b0); emit(1'b1, b, 1'b0); emit(1'b0, b, 1'b0);
  endtask

  task automatic rdBit();
    emit(1'b0, 1'b1, 1'b0); emit(1'b1, 1'b1, 1'b0);
    emit(1'b1, 1'b1, 1'b1); emit(1'b0, 1'b1, 1'b0);
  endtask

  task automatic wrByte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) wrBit(d[i]);
    wrBit(1'b1);
  endtask

  task automatic rdByte(input bit last);
    for (int i = 0; i < 8; i++) rdBit();
    wrBit(last);
  endtask

  task automatic startCond();
    emit(1'b1, 1'b1, 1'b0); emit(1'b1, 1'b0, 1'b0); emit(1'b0, 1'b0, 1'b0);
  endtask

  task automatic stopCond();
    emit(1'b0, 1'b0, 1'b0); emit(1'b1, 1'b0, 1'b0); emit(1'b1, 1'b1, 1'b0);
    endTo(0);
  endtask

  task automatic buildXfer(input logic [6:0] dev, input logic [7:0] regB, input int n);
    beginProg();
    startCond();
    wrByte({dev, 1'b0});
    wrByte(regB);
    startCond();
    wrByte({dev, 1'b1});
    for (int i = 0; i < n; i++) rdByte(i == n - 1);
    stopCond();
  endtask

  // Called at a negedge. extraAt >= 0 pulses start during that step.
  task automatic runSeq(input int nSteps, input int extraAt, input string tag);
    int mism = 0;
    int firstBad = -1;
    base = riseCnt;
    startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
    chk(busy == 1'b1, "R3", {tag, " busy after start"}, 32'(busy), 32'd1);
    chk(rdData == '0, "R8", {tag, " result cleared at start"}, rdData, 32'd0);
    for (int k = 0; k < nSteps; k++) begin
      repeat (k == 0 ? 1 : DIV) @(negedge clk);
      startCmd = 1'b0;
      if (busy !== 1'b1 || (!sclDrvLow) !== expScl[k] || (!sdaDrvLow) !== expSda[k]) begin
        mism++;
        if (firstBad < 0) firstBad = k;
      end
      if (k == extraAt) startCmd = 1'b1;
    end
    chk(mism == 0, "R2 R5 R9 R10", {tag, " step levels (mismatches, first bad step)"},
        32'(mism), 32'(firstBad));
    repeat (DIV - 2) @(negedge clk);
    chk(busy == 1'b1, "R4", {tag, " busy through last step cycle"}, 32'(busy), 32'd1);
    @(negedge clk);
    chk(busy == 1'b0, "R6", {tag, " busy falls after last step"}, 32'(busy), 32'd0);
    chk(!sclDrvLow && !sdaDrvLow, "R5", {tag, " lines released at end"},
        {30'd0, sclDrvLow, sdaDrvLow}, 32'd0);
    chk(rdData == expRes, "R7", {tag, " collected read data"}, rdData, expRes);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1", "busy in reset", 32'(busy), 32'd0);
    chk(!sclDrvLow && !sdaDrvLow, "R1", "lines in reset",
        {30'd0, sclDrvLow, sdaDrvLow}, 32'd0);
    chk(rdData == '0, "R1", "result in reset", rdData, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && !sclDrvLow && !sdaDrvLow, "R1", "idle after reset",
        {29'd0, busy, sclDrvLow, sdaDrvLow}, 32'd0);
    // every entry idle, both lines high, pointing home
    for (int i = 0; i < 1024; i++) ucPut(i, 1'b0, 1'b0, 1'b1, 1'b1, 0);

    // vector table of full write-then-read transfers (R10, R7)
    for (int v = 0; v < 4; v++) begin
      pat = VEC[v][31:0];
      buildXfer(VEC[v][49:43], VEC[v][42:35], int'(VEC[v][34:32]));
      runSeq(pcW - 1, -1, $sformatf("xfer%0d", v));
      repeat (3) @(negedge clk);
    end

    // R9: start pulse mid-run is ignored
    pat = 32'h5A5A_C33C;
    buildXfer(7'h22, 8'h10, 2);
    runSeq(pcW - 1, 5, "R9 restart ignored");
    repeat (3) @(negedge clk);

    // R6: run ends on a non-zero idle entry
    pat = '0;
    beginProg();
    emit(1'b0, 1'b1, 1'b0); emit(1'b1, 1'b1, 1'b0); emit(1'b0, 1'b0, 1'b0);
    endTo(7);
    ucPut(7, 1'b0, 1'b0, 1'b1, 1'b1, 7);
    runSeq(3, -1, "R6 idle entry 7");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule